// File: doc/BRIEF.md
# Serial CRC Signature Analyzer

This block compacts a serial test response into a five-bit signature and turns it into a go/no-go verdict. It is a divider in internal-XOR form for the polynomial 1 + X + X^3 + X^5. The first response bit it receives is the highest-order coefficient, so once the stream has been shifted in, the register holds the remainder of the response polynomial divided by the characteristic polynomial.

A test controller uses it in four steps. It pulses `clr` to load the all-zero seed. It then presents one response bit per clock with `bit_valid` high. It raises `finish` with the last bit or after it. One cycle later `verdict_valid` rises, and `pass` reports whether the remainder matches the fault-free signature given by the parameter `GOLDEN`.

A small controller sequences the work through three states:
- `ST_IDLE` is entered at reset. It ignores everything except a clear, which moves it to `ST_RUN`.
- `ST_RUN` compacts bits. A clear keeps it in `ST_RUN` and reseeds the register. `finish` moves it to `ST_DONE`.
- `ST_DONE` holds the verdict and signature. A clear returns it to `ST_RUN`.

Top module: `crc_sig_analyzer`

## Requirements
- R1: In ST_RUN, a clock edge with bit_valid high and clr low updates signature (bit i holds stage Xi) as X0 <= bit_in ^ X4, X1 <= X0 ^ X4, X2 <= X1, X3 <= X2 ^ X4, X4 <= X3.
- R2: A clock edge with clr high sets signature to 0, clears verdict_valid and pass, and enters ST_RUN, whatever bit_valid and finish are doing in that cycle.
- R3: In ST_RUN, an edge with bit_valid low and clr low leaves signature unchanged.
- R4: After reset and before the first clear (ST_IDLE), bit_valid and finish have no effect: signature stays 0 and verdict_valid stays 0.
- R5: After a clear, signature equals the remainder of dividing the received bits by X^5 + X^3 + X + 1, with the first bit as the highest-order term. The stream 1,0,0,0,1,0,1,0 gives signature 5'b01101 (X0..X4 = 1,0,1,1,0).
- R6: An edge in ST_RUN with finish high and clr low sets verdict_valid from the next cycle on. pass is 1 exactly when the resulting signature equals GOLDEN (default 5'b01101).
- R7: When bit_valid and finish are high in the same ST_RUN cycle, that bit is compacted, and the verdict is made on the signature that includes it.
- R8: In ST_DONE, bit_valid and finish are ignored. signature, verdict_valid and pass hold until the next clear.
- R9: During and right after reset, signature is 0, verdict_valid is 0 and pass is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to the all-zero seed; starts a compaction run |
| bit_valid | input | 1 | bit_in carries a response bit this cycle |
| bit_in | input | 1 | Serial response bit |
| finish | input | 1 | End of response stream; request a verdict |
| signature | output | 5 | Current register contents, bit i = stage Xi |
| verdict_valid | output | 1 | Verdict available; held until clear |
| pass | output | 1 | Signature matched GOLDEN (meaningful when verdict_valid) |

## Verification
The assertions assume that `clr`, `bit_valid`, `bit_in` and `finish` are driven to known values on every edge once reset is released. They also assume that `pass` is read only while `verdict_valid` is high. The bench changes inputs only one time unit after a rising edge, so every input is settled well before the next edge. It draws bits and valid gaps from `$urandom` with a fixed seed, but it only raises `finish` after a clear. Separate directed cases then exercise the idle-state, done-state and clear-priority behaviour.

// File: rtl/crc_sig_pkg.sv
package crc_sig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sig_state_e;
endpackage

// File: rtl/crc_sig_ctrl.sv
module crc_sig_ctrl
    import crc_sig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       bit_valid,
    input  logic       finish,
    output logic       shift_en,
    output logic       capture,
    output sig_state_e state
);
    sig_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (clr) state_d = ST_RUN;
            ST_RUN:  if (clr) state_d = ST_RUN;
                     else if (finish) state_d = ST_DONE;
            ST_DONE: if (clr) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                shift_en = bit_valid & ~clr;
                capture  = finish & ~clr;
            end
            ST_DONE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/crc_sig_lfsr.sv
module crc_sig_lfsr #(
    parameter int          W    = 5,
    parameter logic [W-1:0] TAPS = 5'b01011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    logic         fb;
    logic [W-1:0] shifted;

    assign fb = q[W-1];

    // internal-XOR stages: stage i takes stage i-1, plus feedback where tapped
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign shifted[i] = din ^ (fb & TAPS[i]);
            end else begin : g_rest
                assign shifted[i] = q[i-1] ^ (fb & TAPS[i]);
            end
        end
    endgenerate

    always_comb begin
        if (clr)           q_next = '0;
        else if (shift_en) q_next = shifted;
        else               q_next = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/crc_sig_verdict.sv
module crc_sig_verdict #(
    parameter int           W      = 5,
    parameter logic [W-1:0] GOLDEN = 5'b01101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         capture,
    input  logic [W-1:0] sig_next,
    output logic         done,
    output logic         pass
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else if (clr) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else if (capture) begin
            done <= 1'b1;
            pass <= (sig_next == GOLDEN);
        end
    end
endmodule

// File: rtl/crc_sig_analyzer.sv
module crc_sig_analyzer
    import crc_sig_pkg::*;
#(
    parameter int           W      = 5,
    parameter logic [W-1:0] TAPS   = 5'b01011,
    parameter logic [W-1:0] GOLDEN = 5'b01101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_valid,
    input  logic         bit_in,
    input  logic         finish,
    output logic [W-1:0] signature,
    output logic         verdict_valid,
    output logic         pass
);
    logic         shift_en;
    logic         capture;
    sig_state_e   ctl_state;
    logic [W-1:0] sig_next;

    crc_sig_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bit_valid (bit_valid),
        .finish    (finish),
        .shift_en  (shift_en),
        .capture   (capture),
        .state     (ctl_state)
    );

    crc_sig_lfsr #(.W(W), .TAPS(TAPS)) i_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (shift_en),
        .din      (bit_in),
        .q        (signature),
        .q_next   (sig_next)
    );

    crc_sig_verdict #(.W(W), .GOLDEN(GOLDEN)) i_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .capture  (capture),
        .sig_next (sig_next),
        .done     (verdict_valid),
        .pass     (pass)
    );
endmodule

// File: rtl/crc_sig_checker.sv
module crc_sig_checker
    import crc_sig_pkg::*;
#(
    parameter int           W      = 5,
    parameter logic [W-1:0] TAPS   = 5'b01011,
    parameter logic [W-1:0] GOLDEN = 5'b01101
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         bit_valid,
    input logic         bit_in,
    input logic         finish,
    input logic [W-1:0] signature,
    input logic         verdict_valid,
    input logic         pass,
    input sig_state_e   ctl_state
);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_RUN && bit_valid && !clr) |=>
        signature == ({$past(signature[W-2:0]), $past(bit_in)} ^
                      ($past(signature[W-1]) ? TAPS : '0)));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (signature == '0) && !verdict_valid && !pass && ctl_state == ST_RUN);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_RUN && !bit_valid && !clr) |=> $stable(signature));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_IDLE && !clr) |=> (signature == '0) && !verdict_valid);

    p_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verdict_valid) |-> (pass == (signature == GOLDEN)));

    p_pass_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> verdict_valid);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !clr) |=> verdict_valid && $stable(pass) && $stable(signature));
endmodule

bind crc_sig_analyzer crc_sig_checker #(.W(W), .TAPS(TAPS), .GOLDEN(GOLDEN)) i_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .bit_valid     (bit_valid),
    .bit_in        (bit_in),
    .finish        (finish),
    .signature     (signature),
    .verdict_valid (verdict_valid),
    .pass          (pass),
    .ctl_state     (ctl_state)
);

// File: tb/test_crc_sig_analyzer.sv
`timescale 1ns/1ps
module test_crc_sig_analyzer;
    localparam int          W      = 5;
    localparam logic [5:0]  DIVPOL = 6'b101011; // X^5 + X^3 + X + 1
    localparam logic [4:0]  GOLD   = 5'b01101;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         bit_valid = 1'b0;
    logic         bit_in = 1'b0;
    logic         finish = 1'b0;
    logic [W-1:0] signature;
    logic         verdict_valid;
    logic         pass;

    int checks = 0;
    int errors = 0;
    logic [4:0] model = '0;

    always #2 clk = ~clk;

    crc_sig_analyzer i_crc_sig_analyzer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(bit_valid),
        .bit_in(bit_in), .finish(finish), .signature(signature),
        .verdict_valid(verdict_valid), .pass(pass)
    );

    // remainder update by long division, first bit highest order
    function automatic logic [4:0] div_step(input logic [4:0] r, input logic b);
        logic [5:0] t;
        t = {r, b};
        if (t[5]) t = t ^ DIVPOL;
        return t[4:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic c, input logic v, input logic b, input logic f);
        clr = c; bit_valid = v; bit_in = b; finish = f;
        @(posedge clk); #1;
        clr = 0; bit_valid = 0; bit_in = 0; finish = 0;
    endtask

    task automatic run_stream(input logic [63:0] bits, input int n, input bit gaps, input bit last_with_finish);
        tick(1, 0, 0, 0);
        model = '0;
        chk(signature == 5'd0 && !verdict_valid, "R2 clear", signature, 0);
        for (int k = n - 1; k >= 0; k--) begin
            if (gaps && ($urandom % 3 == 0)) begin
                tick(0, 0, $urandom % 2, 0);
                chk(signature == model, "R3 hold", signature, model);
            end
            if (k == 0 && last_with_finish) begin
                model = div_step(model, bits[k]);
                tick(0, 1, bits[k], 1);
            end else begin
                model = div_step(model, bits[k]);
                tick(0, 1, bits[k], 0);
                chk(signature == model, "R1 step", signature, model);
            end
        end
        if (!last_with_finish) tick(0, 0, 0, 1);
        chk(signature == model, last_with_finish ? "R7 final bit" : "R5 remainder", signature, model);
        chk(verdict_valid == 1'b1, "R6 verdict_valid", verdict_valid, 1);
        chk(pass == (model == GOLD), "R6 pass", pass, (model == GOLD));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0] held_sig;
        logic       held_pass;
        void'($urandom(32'd1234));
        #1;
        chk(signature == 0 && !verdict_valid && !pass, "R9 in reset", signature, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(signature == 0 && !verdict_valid && !pass, "R9 after reset", signature, 0);

        // R4: idle ignores bits and finish
        tick(0, 1, 1, 0);
        tick(0, 1, 1, 1);
        chk(signature == 0, "R4 idle signature", signature, 0);
        chk(!verdict_valid, "R4 idle verdict", verdict_valid, 0);

        // R5: directed example 1,0,0,0,1,0,1,0 -> 01101, passes
        run_stream(64'b10001010, 8, 0, 0);
        chk(signature == GOLD, "R5 example", signature, GOLD);
        chk(pass == 1'b1, "R6 golden pass", pass, 1);

        // R8: done ignores bits and finish
        held_sig = signature; held_pass = pass;
        tick(0, 1, 1, 0);
        tick(0, 1, 0, 1);
        tick(0, 0, 0, 0);
        chk(signature == held_sig, "R8 signature held", signature, held_sig);
        chk(verdict_valid && pass == held_pass, "R8 verdict held", pass, held_pass);

        // R2: clear wins over valid and finish
        tick(1, 1, 1, 1);
        chk(signature == 0, "R2 priority signature", signature, 0);
        chk(!verdict_valid && !pass, "R2 priority verdict", verdict_valid, 0);

        // R7: final bit with finish, example stream -> pass
        run_stream(64'b10001010, 8, 1, 1);
        chk(pass == 1'b1, "R7 pass with last bit", pass, 1);

        // mismatch: one bit flipped -> fail
        run_stream(64'b10001011, 8, 0, 0);
        chk(pass == 1'b0, "R6 mismatch", pass, 0);

        // random streams
        for (int t = 0; t < 60; t++) begin
            logic [63:0] rb;
            rb = {$urandom, $urandom};
            run_stream(rb, 1 + ($urandom % 40), 1, ($urandom % 2) == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule